// File: doc/BRIEF.md
# Per-Band Compressive Gain and Output Mixer

This block sits at the end of a three-band hearing-aid processing chain. For every sample strobe it takes one signed 16-bit sample from each band, the envelope level detected for that band and a hearing-loss setting per band. It turns each envelope into a level in half-decibel steps and derives a level-dependent gain for the band. The gain comes from three anchor gains set by the band's hearing loss, at inputs of 40, 65 and 95 dB SPL, with linear interpolation between them in the log domain.

The gain in half-dB is mapped to a linear Q4.12 multiplier and applied to the band sample with saturation. The three gained bands are added, and the sum is clipped symmetrically at a programmable ceiling, so that loud inputs never exceed a comfortable output. The block is a four-stage pipeline that can accept a new sample on every clock. It is used at the audio sample rate with long idle gaps between strobes.

Top module: `wdrc_gain_mixer`

## Requirements
- R1: After reset, `outValid` is 0 and `outSample` is 0 until the first sample has passed through.
- R2: Each cycle with `inValid` high produces exactly one `outValid` pulse, four clock edges later. Strobes on consecutive cycles give results on consecutive cycles, in order.
- R3: The envelope level L, in half-dB units, is 0 for an envelope of 0. Otherwise L = 12 + 12·p + M[m]. Here p is the bit position of the envelope's leading one, m is the four bits just below it (zero-filled when p < 4), and M[m] = round(12·log2(1 + m/16)).
- R4: Hearing loss h is clamped to 120. With a = max(0, h − 20), the anchor gains in half-dB are: G40 = 2a for h ≤ 60, otherwise 2a − (h − 60); G65 = a; G95 = floor(max(0, h − 40) / 2).
- R5: The band gain g is G40 for L ≤ 80 and G95 for L ≥ 190. For 80 < L ≤ 130 it is G40 + trunc((G65 − G40)(L − 80)/50). For 130 < L < 190 it is G65 + trunc((G95 − G65)(L − 130)/60). Truncation is toward zero.
- R6: g is clamped to 0..47. Writing g = 12q + r, the linear multiplier is round(4096·2^(r/12))·2^q, as unsigned Q4.12.
- R7: Each band result is floor(x·lin/4096), saturated to the range −32768..32767.
- R8: The output is the sum of the three band results, clipped to the range −C..+C, where C is the 15-bit `outCeiling` value.
- R9: Samples, envelopes, hearing-loss values and ceiling are taken only in the cycle `inValid` is high, so later changes do not affect that result. `outSample` holds its value between `outValid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe |
| bandLow | input | 16 | Low band sample, signed |
| bandMid | input | 16 | Middle band sample, signed |
| bandHigh | input | 16 | High band sample, signed |
| envLow | input | 16 | Low band envelope, unsigned |
| envMid | input | 16 | Middle band envelope, unsigned |
| envHigh | input | 16 | High band envelope, unsigned |
| lossLow | input | 7 | Low band hearing loss, dB (0..120) |
| lossMid | input | 7 | Middle band hearing loss, dB (0..120) |
| lossHigh | input | 7 | High band hearing loss, dB (0..120) |
| outCeiling | input | 15 | Symmetric output limit |
| outValid | output | 1 | Result strobe |
| outSample | output | 16 | Mixed, limited output sample, signed |

## Verification
The bench sweeps every leading-one position and mantissa of the envelope, every hearing-loss value up to 127, and envelope levels below, between and above the anchors. A design with a wrong knee, a wrong interpolation rounding, or a missing loss clamp would give a gain that is off by a half-dB step, and the output would differ. Full-scale samples at maximum gain, and small negative samples, catch a missing saturation or a product rounded toward zero instead of floored. Three large bands of equal sign, checked against ceilings from 0 to full scale, expose a sum that wraps around or a limit that is not symmetric. Back-to-back strobes, and inputs changed right after a strobe, expose a wrong latency, a dropped result, or fields read after their sample boundary.

// File: rtl/wdrc_pkg.sv
package wdrc_pkg;
  // Per-stage load strobes, issued by the control to the datapath
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ld4;
  } stage_strb_t;
endpackage

// File: rtl/wdrc_ctrl.sv
module wdrc_ctrl
  import wdrc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output stage_strb_t strb,
  output logic        outValid
);
  localparam int DEPTH = 4;

  logic [DEPTH-1:0] validPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) validPipe <= '0;
    else        validPipe <= {validPipe[DEPTH-2:0], inValid};
  end

  always_comb begin
    strb.ld1 = inValid;
    strb.ld2 = validPipe[0];
    strb.ld3 = validPipe[1];
    strb.ld4 = validPipe[2];
  end

  assign outValid = validPipe[DEPTH-1];

  AST_FOUR_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid, 4)); // R2
endmodule

// File: rtl/wdrc_lane.sv
module wdrc_lane #(
  parameter int SAMPLE_W   = 16,
  parameter int ENV_W      = 16,
  parameter int LOSS_W     = 7,
  parameter int LOSS_MAX   = 120,
  parameter int GAIN_MAX   = 47,
  parameter int LVL_OFFSET = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld1,
  input  logic                       ld2,
  input  logic                       ld3,
  input  logic signed [SAMPLE_W-1:0] xIn,
  input  logic        [ENV_W-1:0]    envIn,
  input  logic        [LOSS_W-1:0]   lossIn,
  output logic signed [SAMPLE_W-1:0] yOut
);
  localparam int POS_W   = $clog2(ENV_W);
  localparam int LVL_MAX = LVL_OFFSET + 12 * (ENV_W - 1) + 11;
  localparam int LVL_W   = $clog2(LVL_MAX + 1);
  localparam int GAIN_W  = $clog2(GAIN_MAX + 1);
  localparam int LIN_W   = 16;
  localparam int FRAC    = 12;
  localparam int PROD_W  = SAMPLE_W + LIN_W + 1;
  localparam int A_LO    = 80;   // 40 dB in half-dB steps
  localparam int A_MID   = 130;  // 65 dB
  localparam int A_HI    = 190;  // 95 dB
  localparam int KNEE_A  = 20;
  localparam int KNEE_B  = 60;
  localparam int KNEE_C  = 40;
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'(2 ** (SAMPLE_W - 1) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - PROD_W'(1);

  function automatic logic [3:0] mantHalf(input logic [3:0] m);
    case (m)
      4'd0: return 4'd0;   4'd1: return 4'd1;   4'd2: return 4'd2;   4'd3: return 4'd3;
      4'd4: return 4'd4;   4'd5: return 4'd5;   4'd6: return 4'd6;   4'd7: return 4'd6;
      4'd8: return 4'd7;   4'd9: return 4'd8;   4'd10: return 4'd8;  4'd11: return 4'd9;
      4'd12: return 4'd10; 4'd13: return 4'd10; 4'd14: return 4'd11; default: return 4'd11;
    endcase
  endfunction

  function automatic logic [LIN_W-1:0] linStep(input logic [3:0] r);
    case (r)
      4'd0: return 16'd4096;  4'd1: return 16'd4340;  4'd2: return 16'd4598;
      4'd3: return 16'd4871;  4'd4: return 16'd5161;  4'd5: return 16'd5468;
      4'd6: return 16'd5793;  4'd7: return 16'd6137;  4'd8: return 16'd6502;
      4'd9: return 16'd6889;  4'd10: return 16'd7298; 4'd11: return 16'd7732;
      default: return 16'd4096;
    endcase
  endfunction

  // ---- stage 1: envelope to level, loss clamp ----
  logic [POS_W-1:0]  leadPos;
  logic [3:0]        mant;
  logic [LVL_W-1:0]  lvlC, lvlS1;
  logic [LOSS_W-1:0] lossC, lossS1;
  logic signed [SAMPLE_W-1:0] xS1, xS2;

  always_comb begin
    leadPos = '0;
    for (int i = 0; i < ENV_W; i++)
      if (envIn[i]) leadPos = POS_W'(i);
    mant = 4'({envIn, 4'b0000} >> leadPos);
    if (envIn == '0) lvlC = '0;
    else lvlC = LVL_W'(LVL_OFFSET + 12 * int'(leadPos) + int'(mantHalf(mant)));
    lossC = (lossIn > LOSS_W'(LOSS_MAX)) ? LOSS_W'(LOSS_MAX) : lossIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xS1 <= '0; lvlS1 <= '0; lossS1 <= '0;
    end else if (ld1) begin
      xS1 <= xIn; lvlS1 <= lvlC; lossS1 <= lossC;
    end
  end

  // ---- stage 2: anchors and interpolation ----
  int hI, lI, aI, g40, g65, g95, gI;
  logic [GAIN_W-1:0] gainC, gainS2;

  always_comb begin
    hI  = int'(lossS1);
    lI  = int'(lvlS1);
    aI  = (hI > KNEE_A) ? hI - KNEE_A : 0;
    g40 = (hI <= KNEE_B) ? 2 * aI : 2 * aI - (hI - KNEE_B);
    g65 = aI;
    g95 = (hI > KNEE_C) ? (hI - KNEE_C) / 2 : 0;
    if (lI <= A_LO)       gI = g40;
    else if (lI <= A_MID) gI = g40 + ((g65 - g40) * (lI - A_LO)) / (A_MID - A_LO);
    else if (lI < A_HI)   gI = g65 + ((g95 - g65) * (lI - A_MID)) / (A_HI - A_MID);
    else                  gI = g95;
    if (gI > GAIN_MAX) gI = GAIN_MAX;
    if (gI < 0)        gI = 0;
    gainC = GAIN_W'(gI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xS2 <= '0; gainS2 <= '0;
    end else if (ld2) begin
      xS2 <= xS1; gainS2 <= gainC;
    end
  end

  // ---- stage 3: linear gain, product, saturation ----
  logic [GAIN_W-1:0]        octave;
  logic [3:0]               semis;
  logic [LIN_W-1:0]         lin;
  logic signed [PROD_W-1:0] prod, scaled;
  logic signed [SAMPLE_W-1:0] satC, yS3;

  always_comb begin
    octave = gainS2 / GAIN_W'(12);
    semis  = 4'(gainS2 % GAIN_W'(12));
    lin    = linStep(semis) << octave;
    prod   = PROD_W'(xS2) * PROD_W'($signed({1'b0, lin}));
    scaled = prod >>> FRAC;
    if (scaled > SAT_HI)      satC = SAMPLE_W'(SAT_HI);
    else if (scaled < SAT_LO) satC = SAMPLE_W'(SAT_LO);
    else                      satC = SAMPLE_W'(scaled);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   yS3 <= '0;
    else if (ld3) yS3 <= satC;
  end

  assign yOut = yS3;

  AST_LEVEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ld1 |=> ((lvlS1 == '0) == ($past(envIn) == '0))); // R3
  AST_ANCHOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ld1 |=> (g40 >= g65 && g65 >= g95)); // R4
  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ld3 |=> (yS3[SAMPLE_W-1] == $past(xS2[SAMPLE_W-1]))); // R7
endmodule

// File: rtl/wdrc_datapath.sv
module wdrc_datapath
  import wdrc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ENV_W    = 16,
  parameter int LOSS_W   = 7,
  parameter int NB       = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  stage_strb_t                      strb,
  input  logic [NB-1:0][SAMPLE_W-1:0]      xIn,
  input  logic [NB-1:0][ENV_W-1:0]         envIn,
  input  logic [NB-1:0][LOSS_W-1:0]        lossIn,
  input  logic [SAMPLE_W-2:0]              ceilIn,
  output logic [SAMPLE_W-1:0]              outSample
);
  localparam int CEIL_W = SAMPLE_W - 1;
  localparam int SUM_W  = SAMPLE_W + $clog2(NB) + 1;

  logic [NB-1:0][SAMPLE_W-1:0] yLane;
  logic [CEIL_W-1:0] c1, c2, c3;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    wdrc_lane #(
      .SAMPLE_W(SAMPLE_W), .ENV_W(ENV_W), .LOSS_W(LOSS_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .ld1(strb.ld1), .ld2(strb.ld2), .ld3(strb.ld3),
      .xIn($signed(xIn[b])), .envIn(envIn[b]), .lossIn(lossIn[b]),
      .yOut(yLane[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1 <= '0; c2 <= '0; c3 <= '0;
    end else begin
      if (strb.ld1) c1 <= ceilIn;
      if (strb.ld2) c2 <= c1;
      if (strb.ld3) c3 <= c2;
    end
  end

  logic signed [SUM_W-1:0] sumC, cPos, cNeg, clipC;

  always_comb begin
    sumC = '0;
    for (int b = 0; b < NB; b++)
      sumC = sumC + SUM_W'($signed(yLane[b]));
    cPos = $signed(SUM_W'(c3));
    cNeg = -cPos;
    if (sumC > cPos)      clipC = cPos;
    else if (sumC < cNeg) clipC = cNeg;
    else                  clipC = sumC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        outSample <= '0;
    else if (strb.ld4) outSample <= SAMPLE_W'(clipC);
  end

  AST_OUT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ld4 |=> ($signed({outSample[SAMPLE_W-1], outSample}) <= $signed({2'b00, $past(c3)}) &&
                  $signed({outSample[SAMPLE_W-1], outSample}) >= -$signed({2'b00, $past(c3)}))); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.ld4 |=> $stable(outSample)); // R9
endmodule

// File: rtl/wdrc_gain_mixer.sv
module wdrc_gain_mixer
  import wdrc_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ENV_W    = 16,
  parameter int LOSS_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] bandLow,
  input  logic [SAMPLE_W-1:0] bandMid,
  input  logic [SAMPLE_W-1:0] bandHigh,
  input  logic [ENV_W-1:0]    envLow,
  input  logic [ENV_W-1:0]    envMid,
  input  logic [ENV_W-1:0]    envHigh,
  input  logic [LOSS_W-1:0]   lossLow,
  input  logic [LOSS_W-1:0]   lossMid,
  input  logic [LOSS_W-1:0]   lossHigh,
  input  logic [SAMPLE_W-2:0] outCeiling,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outSample
);
  localparam int NB = 3;

  stage_strb_t strb;

  wdrc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .strb(strb), .outValid(outValid)
  );

  wdrc_datapath #(
    .SAMPLE_W(SAMPLE_W), .ENV_W(ENV_W), .LOSS_W(LOSS_W), .NB(NB)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .xIn({bandHigh, bandMid, bandLow}),
    .envIn({envHigh, envMid, envLow}),
    .lossIn({lossHigh, lossMid, lossLow}),
    .ceilIn(outCeiling),
    .outSample(outSample)
  );
endmodule

// File: tb/wdrc_gain_mixer_test.sv
module wdrc_gain_mixer_test;
  logic clk = 0;
  logic rst_n = 0;
  logic inValid = 0;
  logic signed [15:0] xb [3];
  logic [15:0] eb [3];
  logic [6:0]  hb [3];
  logic [14:0] ceilIn;
  logic outValid;
  logic [15:0] outSample;
  int nChecks = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wdrc_gain_mixer uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .bandLow(xb[0]), .bandMid(xb[1]), .bandHigh(xb[2]),
    .envLow(eb[0]), .envMid(eb[1]), .envHigh(eb[2]),
    .lossLow(hb[0]), .lossMid(hb[1]), .lossHigh(hb[2]),
    .outCeiling(ceilIn), .outValid(outValid), .outSample(outSample)
  );

  task automatic chk(input string tag, input int act, input int expv);
    nChecks++;
    if (act != expv) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int lvlOf(int env);
    int p, m, mt;
    if (env == 0) return 0;
    p = 0;
    for (int i = 0; i < 16; i++) if ((env >> i) & 1) p = i;
    m = ((env << 4) >> p) & 15;
    mt = $rtoi(12.0 * $ln(1.0 + m / 16.0) / $ln(2.0) + 0.5);
    return 12 + 12 * p + mt;
  endfunction

  function automatic int gainOf(int hIn, int lv);
    int h, a, g40, g65, g95, g;
    h = (hIn > 120) ? 120 : hIn;
    a = (h > 20) ? h - 20 : 0;
    g40 = (h <= 60) ? 2 * a : 2 * a - (h - 60);
    g65 = a;
    g95 = (h > 40) ? (h - 40) / 2 : 0;
    if (lv <= 80) g = g40;
    else if (lv <= 130) g = g40 + ((g65 - g40) * (lv - 80)) / 50;
    else if (lv < 190) g = g65 + ((g95 - g65) * (lv - 130)) / 60;
    else g = g95;
    if (g > 47) g = 47;
    if (g < 0) g = 0;
    return g;
  endfunction

  function automatic int linOf(int g);
    int q, r;
    q = g / 12; r = g % 12;
    return $rtoi($pow(2.0, r / 12.0) * 4096.0 + 0.5) << q;
  endfunction

  function automatic int bandOf(int x, int env, int h);
    longint p, y;
    p = longint'(x) * longint'(linOf(gainOf(h, lvlOf(env))));
    y = p >>> 12;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  function automatic int modelMix();
    int s, c;
    s = 0;
    for (int b = 0; b < 3; b++) s += bandOf(int'(xb[b]), int'(eb[b]), int'(hb[b]));
    c = int'(ceilIn);
    if (s > c) s = c;
    if (s < -c) s = -c;
    return s;
  endfunction

  function automatic int outNow();
    return int'($signed(outSample));
  endfunction

  // one isolated sample: drive at a falling edge, check four edges later
  task automatic runOne(input string tag, input bit scramble);
    int expv;
    expv = modelMix();
    @(negedge clk); inValid = 1;
    @(negedge clk); inValid = 0;
    if (scramble) begin
      for (int b = 0; b < 3; b++) begin
        xb[b] = ~xb[b]; eb[b] = ~eb[b]; hb[b] = 7'd100;
      end
      ceilIn = 15'd5;
    end
    repeat (2) begin
      @(negedge clk);
      chk({tag, " early valid"}, int'(outValid), 0);
    end
    @(negedge clk);
    chk({tag, " valid"}, int'(outValid), 1);
    chk(tag, outNow(), expv);
  endtask

  task automatic clearIn();
    for (int b = 0; b < 3; b++) begin xb[b] = 0; eb[b] = 0; hb[b] = 0; end
    ceilIn = 15'd32767;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    int expArr [8];
    clearIn();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset valid", int'(outValid), 0);
    chk("R1 reset sample", outNow(), 0);

    // R3: every leading-one position and mantissa, plus zero envelope
    clearIn();
    for (int b = 0; b < 3; b++) hb[b] = 7'd40;
    xb[0] = 16'sd1000;
    eb[0] = 0;
    runOne("R3 zero env", 0);
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 16; m++) begin
        eb[0] = (p >= 4) ? 16'((16 + m) << (p - 4)) : 16'((16 + m) >> (4 - p));
        runOne("R3 level", 0);
      end
    end

    // R4 R5 R6: hearing-loss sweep across levels and lanes
    for (int h = 0; h < 128; h++) begin
      for (int k = 0; k < 16; k++) begin
        int b;
        clearIn();
        b = (h + k) % 3;
        for (int o = 0; o < 3; o++) begin
          hb[o] = 7'((h * 7 + o) % 128);
          eb[o] = 16'(k * 977 + o);
        end
        xb[b] = 16'(300 + k * 37);
        eb[b] = 16'(1 << k);
        hb[b] = 7'(h);
        if (h > 120) runOne("R4 loss clamp", 0);
        else if (k < 6) runOne("R6 low-level gain", 0);
        else runOne("R5 interpolation", 0);
      end
    end

    // R7: saturation and floor rounding
    begin
      int xs [8] = '{-32768, -20000, -1, 0, 1, 7, 20000, 32767};
      int hs [4] = '{0, 30, 43, 60};
      foreach (xs[i]) foreach (hs[j]) begin
        clearIn();
        xb[1] = 16'(xs[i]); eb[1] = 16'd1; hb[1] = 7'(hs[j]);
        runOne("R7 band product", 0);
      end
    end

    // R8: three-band sum with symmetric ceiling
    begin
      int xs [4] = '{30000, -30000, 12345, -20000};
      int cs [5] = '{0, 1, 1000, 20000, 32767};
      foreach (xs[i]) foreach (cs[j]) begin
        clearIn();
        for (int b = 0; b < 3; b++) begin
          xb[b] = 16'(xs[i]); eb[b] = 16'(1 << (4 * b + 2)); hb[b] = 7'(15 * b + 5);
        end
        ceilIn = 15'(cs[j]);
        runOne("R8 ceiling", 0);
      end
    end

    // R2: back-to-back strobes
    clearIn();
    for (int cyc = 0; cyc <= 12; cyc++) begin
      @(negedge clk);
      if (cyc >= 4 && cyc - 4 < 8) begin
        chk("R2 burst valid", int'(outValid), 1);
        chk("R2 burst order", outNow(), expArr[cyc - 4]);
      end else begin
        chk("R2 burst idle", int'(outValid), 0);
      end
      if (cyc < 8) begin
        for (int b = 0; b < 3; b++) begin
          xb[b] = 16'(cyc * 2100 - 7000 + b * 500);
          eb[b] = 16'(1 << (cyc + b));
          hb[b] = 7'(cyc * 13 + b * 4);
        end
        ceilIn = 15'(3000 + cyc * 3000);
        expArr[cyc] = modelMix();
        inValid = 1;
      end else begin
        inValid = 0;
      end
    end

    // R9: inputs changed after the strobe, then output hold
    clearIn();
    for (int b = 0; b < 3; b++) begin
      xb[b] = 16'(4000 - 3000 * b); eb[b] = 16'(50 << b); hb[b] = 7'(30 + 10 * b);
    end
    ceilIn = 15'd9000;
    runOne("R9 capture", 1);
    begin
      int held;
      held = outNow();
      repeat (3) begin
        @(negedge clk);
        chk("R9 hold valid", int'(outValid), 0);
        chk("R9 hold sample", outNow(), held);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule